// File: doc/BRIEF.md
# Module Status and Reset Controller

This block is the housekeeping logic of a plug-on FPGA module. It watches three asynchronous status inputs from the module: an active-low reset request from the carrier board, an aggregate power-good flag and the FPGA configuration-done flag. From these it reports the module's condition on one status LED. The LED is either lit steadily or blinks at one of three rates. The block also passes the reset request to the FPGA as an active-low program request, drives an active-high power-good output to the carrier, and drives a second LED that is lit while the FPGA is unconfigured.

All status inputs pass through two-flop synchronisers. A four-state machine picks the module condition by fixed priority. The states are ST_HOLD (reset held), ST_FAULT (power-good low), ST_UNCONF (powered but not configured) and ST_READY (powered and configured). The machine can move from any state to any other in one step. The transitions are named by cause: assert-reset goes to ST_HOLD, power-loss goes to ST_FAULT, config-loss goes to ST_UNCONF and config-done goes to ST_READY. Release-reset leaves ST_HOLD for the highest-priority condition that remains. A blink generator restarts its half-period counter in the on phase whenever the state changes.

Two further inputs control the status LED. When the route request is high and the JTAG-select input is low, the LED shows a user input pin instead of the pattern. Both of these control inputs are synchronised first. A high JTAG-select blocks the route request.

Top module: `modstat_ctrl`

## Requirements
- R1: While the synchronised reset request is low, the status LED is lit steadily, whatever power-good and configuration-done show.
- R2: With reset released and power-good low, the status LED blinks with CLK_HZ/10 cycles on and CLK_HZ/10 cycles off.
- R3: With reset released, power-good high and configuration-done low, the LED blinks with CLK_HZ/2 cycles on and CLK_HZ/2 cycles off.
- R4: With reset released, power-good high and configuration-done high, the LED blinks with CLK_HZ cycles on and CLK_HZ cycles off.
- R5: prog_req_n is low while the reset request is held low, and it goes high once the release has passed the synchroniser.
- R6: pwr_good_out is high exactly when the synchronised power-good input is high.
- R7: cfg_led is the inverse of the synchronised configuration-done input, so it is lit while the FPGA is unconfigured.
- R8: When led_route_req is 1 and jtag_sel is 0 (both synchronised), status_led equals user_led_in. Otherwise status_led carries the internal pattern.
- R9: The condition priority is fixed: reset over power fault, power fault over unconfigured, unconfigured over ready.
- R10: Each status input reaches the direct outputs two clock edges after it is sampled, and reaches the LED pattern state on the third edge.
- R11: On every change of the selected condition, the blink counter restarts and the LED begins a full on half-period, even if the previous pattern was in its off phase.
- R12: While arst_n is low, status_led is 1, prog_req_n is 0, pwr_good_out is 0 and cfg_led is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | Reset request from carrier, active low, asynchronous |
| pwr_good_in | input | 1 | Aggregate supply-good flag, asynchronous |
| cfg_done_in | input | 1 | FPGA configuration-done flag, asynchronous |
| jtag_sel | input | 1 | High while the controller itself is selected on JTAG; blocks LED routing |
| led_route_req | input | 1 | Request to hand the status LED to user_led_in |
| user_led_in | input | 1 | User-driven LED value |
| status_led | output | 1 | Status LED, 1 = lit |
| cfg_led | output | 1 | Unconfigured indicator, 1 = lit |
| prog_req_n | output | 1 | FPGA program request, active low |
| pwr_good_out | output | 1 | Power-good report to carrier, active high |

## Verification
The hardest situation to reach is a change of condition while the current blink is in its off phase. This is the only case where a missing counter restart shows up as a wrong LED level and not just as a different rate. The bench holds the module ready until the slow pattern is well inside its off half, then drops configuration-done. It then expects the medium pattern to start with a full on half-period. The state sweep goes back to the reset state before each input combination, so every combination starts from a real condition change. Each combination is then compared cycle by cycle for two full blink periods against a pattern computed from CLK_HZ.

// File: rtl/modstat_pkg.sv
package modstat_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_FAULT  = 2'd1,
        ST_UNCONF = 2'd2,
        ST_READY  = 2'd3
    } mod_state_e;

    localparam int SYNC_W = 5;
    localparam int SI_RST = 4;
    localparam int SI_PWR = 3;
    localparam int SI_CFG = 2;
    localparam int SI_JTG = 1;
    localparam int SI_RTE = 0;

endpackage

// File: rtl/modstat_sync.sv
module modstat_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[g] <= '0;
                    else         chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[g] <= '0;
                    else         chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/modstat_fsm.sv
module modstat_fsm
    import modstat_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       rst_ok,
    input  logic       pwr_ok,
    input  logic       cfg_ok,
    output mod_state_e state,
    output mod_state_e nxt
);
    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_HOLD;
        else         state <= nxt;
    end

    // transitions: assert-reset, power-loss, config-loss, config-done,
    // release-reset
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (rst_ok) begin
                    if (!pwr_ok)      nxt = ST_FAULT;
                    else if (!cfg_ok) nxt = ST_UNCONF;
                    else              nxt = ST_READY;
                end
            end
            ST_FAULT: begin
                if (!rst_ok)         nxt = ST_HOLD;
                else if (pwr_ok)     nxt = cfg_ok ? ST_READY : ST_UNCONF;
            end
            ST_UNCONF: begin
                if (!rst_ok)         nxt = ST_HOLD;
                else if (!pwr_ok)    nxt = ST_FAULT;
                else if (cfg_ok)     nxt = ST_READY;
            end
            ST_READY: begin
                if (!rst_ok)         nxt = ST_HOLD;
                else if (!pwr_ok)    nxt = ST_FAULT;
                else if (!cfg_ok)    nxt = ST_UNCONF;
            end
            default:                 nxt = ST_HOLD;
        endcase
    end

endmodule

// File: rtl/modstat_blink.sv
module modstat_blink
    import modstat_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic                              clk,
    input  logic                              arst_n,
    input  mod_state_e                        state,
    input  mod_state_e                        nxt,
    output logic                              phase,
    output logic [$clog2(CLK_HZ+1)-1:0]       cnt
);
    localparam int HALF_FAST = CLK_HZ / 10;
    localparam int HALF_MED  = CLK_HZ / 2;
    localparam int HALF_SLOW = CLK_HZ;
    localparam int CW        = $clog2(HALF_SLOW + 1);

    logic [CW-1:0] lim;
    logic          restart;

    assign restart = (nxt != state);

    always_comb begin
        unique case (state)
            ST_FAULT:  lim = CW'(HALF_FAST);
            ST_UNCONF: lim = CW'(HALF_MED);
            ST_READY:  lim = CW'(HALF_SLOW);
            default:   lim = CW'(HALF_SLOW);
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (restart) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (cnt == lim - CW'(1)) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/modstat_ctrl.sv
module modstat_ctrl
    import modstat_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic ext_rst_n,
    input  logic pwr_good_in,
    input  logic cfg_done_in,
    input  logic jtag_sel,
    input  logic led_route_req,
    input  logic user_led_in,
    output logic status_led,
    output logic cfg_led,
    output logic prog_req_n,
    output logic pwr_good_out
);
    localparam int CW = $clog2(CLK_HZ + 1);

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn_in;
    mod_state_e        state;
    mod_state_e        nxt;
    logic              phase;
    logic [CW-1:0]     blink_cnt;
    logic              route_sel;
    logic              pattern;

    assign raw_in = {ext_rst_n, pwr_good_in, cfg_done_in, jtag_sel, led_route_req};

    modstat_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (raw_in),
        .q      (syn_in)
    );

    modstat_fsm u_fsm (
        .clk    (clk),
        .arst_n (arst_n),
        .rst_ok (syn_in[SI_RST]),
        .pwr_ok (syn_in[SI_PWR]),
        .cfg_ok (syn_in[SI_CFG]),
        .state  (state),
        .nxt    (nxt)
    );

    modstat_blink #(.CLK_HZ(CLK_HZ)) u_blink (
        .clk    (clk),
        .arst_n (arst_n),
        .state  (state),
        .nxt    (nxt),
        .phase  (phase),
        .cnt    (blink_cnt)
    );

    // output process
    always_comb begin
        route_sel    = syn_in[SI_RTE] & ~syn_in[SI_JTG];
        pattern      = (state == ST_HOLD) ? 1'b1 : phase;
        status_led   = route_sel ? user_led_in : pattern;
        cfg_led      = ~syn_in[SI_CFG];
        prog_req_n   = syn_in[SI_RST];
        pwr_good_out = syn_in[SI_PWR];
    end

endmodule

// File: rtl/modstat_chk.sv
module modstat_chk
    import modstat_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input logic                         clk,
    input logic                         arst_n,
    input logic                         ext_rst_n,
    input logic                         status_led,
    input logic                         cfg_led,
    input logic                         prog_req_n,
    input logic                         pwr_good_out,
    input mod_state_e                   state,
    input logic                         phase,
    input logic [$clog2(CLK_HZ+1)-1:0]  cnt,
    input logic                         route_sel
);
    localparam int HALF_SLOW = CLK_HZ;

    // R1
    hold_lit_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_HOLD && !route_sel) |-> status_led);

    // R5
    prog_held_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!$past(ext_rst_n) && !$past(ext_rst_n, 2)) |-> !prog_req_n);

    // R11
    restart_on_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state != $past(state)) |-> (phase && cnt == '0));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cnt < ($clog2(CLK_HZ+1))'(HALF_SLOW));

    // R2
    toggle_edge_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ($rose(phase) || $fell(phase)) |-> (cnt == '0));

    // R9
    ready_inputs_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_READY) |-> ($past(pwr_good_out) && !$past(cfg_led) && $past(prog_req_n)));

endmodule

bind modstat_ctrl modstat_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .ext_rst_n    (ext_rst_n),
    .status_led   (status_led),
    .cfg_led      (cfg_led),
    .prog_req_n   (prog_req_n),
    .pwr_good_out (pwr_good_out),
    .state        (state),
    .phase        (phase),
    .cnt          (blink_cnt),
    .route_sel    (route_sel)
);

// File: tb/sim_modstat_ctrl.sv
`timescale 1ns/1ps
module sim_modstat_ctrl;
    localparam int HZ   = 100;
    localparam int FAST = HZ / 10;
    localparam int MED  = HZ / 2;
    localparam int SLOW = HZ;

    logic clk = 1'b0;
    logic arst_n, ext_rst_n, pwr_good_in, cfg_done_in, jtag_sel, led_route_req, user_led_in;
    logic status_led, cfg_led, prog_req_n, pwr_good_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    modstat_ctrl #(.CLK_HZ(HZ)) u0 (
        .clk(clk), .arst_n(arst_n), .ext_rst_n(ext_rst_n),
        .pwr_good_in(pwr_good_in), .cfg_done_in(cfg_done_in),
        .jtag_sel(jtag_sel), .led_route_req(led_route_req),
        .user_led_in(user_led_in), .status_led(status_led),
        .cfg_led(cfg_led), .prog_req_n(prog_req_n), .pwr_good_out(pwr_good_out)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic int half_of(input bit p, input bit d);
        return !p ? FAST : (!d ? MED : SLOW);
    endfunction

    // follow the pattern after a condition change applied at the last negedge
    task automatic watch(input bit r, input bit p, input bit d, input int n, input string req);
        int h;
        h = half_of(p, d);
        repeat (3) @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(status_led, !r ? 1'b1 : (((k / h) % 2) == 0), req, "status_led pattern");
            if (k == 0) begin
                chk(prog_req_n, r, "R5", "prog_req_n");
                chk(pwr_good_out, p, "R6", "pwr_good_out");
                chk(cfg_led, !d, "R7", "cfg_led");
            end
        end
    endtask

    task automatic run_case(input bit r, input bit p, input bit d);
        string req;
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_rst_n = r; pwr_good_in = p; cfg_done_in = d;
        if (!r)      req = "R1 R9";
        else if (!p) req = "R2 R9";
        else if (!d) req = "R3 R9";
        else         req = "R4";
        watch(r, p, d, 4 * half_of(p, d), req);
    endtask

    initial begin
        arst_n = 1'b0; ext_rst_n = 1'b1; pwr_good_in = 1'b1; cfg_done_in = 1'b1;
        jtag_sel = 1'b0; led_route_req = 1'b0; user_led_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(status_led, 1'b1, "R12", "status_led in reset");
        chk(prog_req_n, 1'b0, "R12", "prog_req_n in reset");
        chk(pwr_good_out, 1'b0, "R12", "pwr_good_out in reset");
        chk(cfg_led, 1'b1, "R12", "cfg_led in reset");

        arst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(prog_req_n, 1'b0, "R10", "prog_req_n after one edge");
        chk(pwr_good_out, 1'b0, "R10", "pwr_good_out after one edge");
        @(posedge clk); @(negedge clk);
        chk(prog_req_n, 1'b1, "R10", "prog_req_n after two edges");
        chk(pwr_good_out, 1'b1, "R10", "pwr_good_out after two edges");
        chk(cfg_led, 1'b0, "R10", "cfg_led after two edges");

        // sweep of every input combination
        for (int i = 0; i < 8; i++) run_case(i[2], i[1], i[0]);

        // R11: change of condition during the off half of the slow blink
        run_case(1'b1, 1'b1, 1'b1);
        repeat (150) @(negedge clk);
        cfg_done_in = 1'b0;
        watch(1'b1, 1'b1, 1'b0, 2 * MED, "R11");

        // R8: routing of the LED to the user pin, reset held so pattern is 1
        @(negedge clk);
        ext_rst_n = 1'b0;
        for (int j = 0; j < 8; j++) begin
            jtag_sel = j[2]; led_route_req = j[1]; user_led_in = j[0];
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(status_led, (j[1] && !j[2]) ? j[0] : 1'b1, "R8", "status_led routing");
        end
        led_route_req = 1'b0; jtag_sel = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule